// File: doc/BRIEF.md
# LED Brightness PWM Controller

This block dims an LED by pulse-width modulation, running from a free-running reference clock. A single 16-bit control word is written through an address/data write port. The word chooses four things: a power-of-two period scale, a 5-bit brightness level that gives 32 steps, a run bit that takes the block out of power-down, and the pin drive style.

Each PWM period lasts 2^(DIV+7) reference cycles and is cut into 32 equal steps. The pin is high for the first (level+1) steps and low for the remaining steps. The output is a data value plus an output-enable, so a pad can use it either as a push-pull driver or as an open-drain driver.

Level and scale values written while the block runs are held back until the current period ends. Each period is therefore complete and never glitched.

Top module: `ledpwm_top`

## Requirements
- R1: A write with `wr_en` high and `wr_addr` equal to 18h loads the control word. The fields are: bit 15 is the drive style (0 push-pull, 1 open drain), bits 12:8 are the level LVL, bit 6 is the run bit, and bits 2:0 are the scale index DIV. The other bits have no effect.
- R2: After reset every field is zero. The block is powered down in push-pull mode with `pwm_o` = 0 and `pwm_oe` = 1.
- R3: While running, the waveform repeats with a period of exactly 2^(DIV+7) reference cycles.
- R4: While running, each period is high for (LVL+1)·2^(DIV+2) cycles and then low for (31−LVL)·2^(DIV+2) cycles.
- R5: LVL = 31 gives a level that stays high without a break.
- R6: When the run bit is 0, the pin reads low from the cycle after the write and the step counters are held at zero. When the run bit is set again, the waveform starts with the high part of a fresh period in the first cycle after the write.
- R7: In push-pull mode `pwm_oe` is 1 and `pwm_o` carries the level. In open-drain mode `pwm_o` is 0 and `pwm_oe` is 1 only while the level is low.
- R8: A new LVL or DIV written while running first shapes the period that begins after the current period ends. The current period finishes with the old values.
- R9: A write to any address other than 18h leaves the block's behaviour unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 16 | Write data |
| pwm_o | output | 1 | Pin data value |
| pwm_oe | output | 1 | Pin output enable |

## Verification
A prescaler or step counter in the wrong state shows up at the pin as wrong high or low run lengths. This is visible within one period, which is at most 16384 cycles. A wrongly latched shadow value shows up as a wrong first period after a mid-period write. A run bit that does not force the pin low, or a wrong drive-style decode, shows up at the pin in the first cycle after the write. Because of this, the bench measures consecutive high and low run lengths at the pins and compares them with lengths computed from the requirements.

// File: rtl/ledpwm_pkg.sv
package ledpwm_pkg;

    localparam int LVL_W    = 5;
    localparam int DIV_W    = 3;
    localparam int DIV_BASE = 2;
    localparam int PRE_W    = DIV_BASE + (1 << DIV_W) - 1;
    localparam int WORD_W   = 16;

    localparam int POS_OD  = 15;
    localparam int POS_LVL = 8;
    localparam int POS_RUN = 6;
    localparam int POS_DIV = 0;

    typedef enum logic {
        DRV_PUSHPULL  = 1'b0,
        DRV_OPENDRAIN = 1'b1
    } drive_e;

    typedef struct packed {
        logic              drive_od;
        logic [LVL_W-1:0]  level;
        logic              run;
        logic [DIV_W-1:0]  div_idx;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.drive_od = w[POS_OD];
        c.level    = w[POS_LVL +: LVL_W];
        c.run      = w[POS_RUN];
        c.div_idx  = w[POS_DIV +: DIV_W];
        return c;
    endfunction

    function automatic logic [PRE_W-1:0] tick_limit(input logic [DIV_W-1:0] d);
        return PRE_W'((32'd1 << (32'(d) + DIV_BASE)) - 32'd1);
    endfunction

endpackage

// File: rtl/ledpwm_regs.sv
module ledpwm_regs
    import ledpwm_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output ctrl_t             ctrl_q,
    output ctrl_t             ctrl_d
);

    logic hit;
    assign hit = wr_en && (wr_addr == CTRL_ADDR);

    always_comb begin
        ctrl_d = ctrl_q;
        if (hit) ctrl_d = unpack_ctrl(wr_data);
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    assert_foreign_addr_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != CTRL_ADDR) |=> $stable(ctrl_q));

endmodule

// File: rtl/ledpwm_prescaler.sv
module ledpwm_prescaler
    import ledpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_idx,
    output logic             tick
);

    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] limit;

    assign limit = tick_limit(div_idx);
    assign tick  = run && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    assert_prescale_count_R3: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> (!run || cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/ledpwm_stepper.sv
module ledpwm_stepper
    import ledpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  ctrl_t            ctrl_d,
    output logic [DIV_W-1:0] act_div,
    output logic             pwm_hi
);

    logic [LVL_W-1:0] step;
    logic [LVL_W-1:0] act_lvl;
    logic             wrap;

    assign wrap   = tick && (step == '1);
    assign pwm_hi = run && (step <= act_lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            step    <= '0;
            act_lvl <= '0;
            act_div <= '0;
        end else if (!run) begin
            step    <= '0;
            act_lvl <= ctrl_d.level;
            act_div <= ctrl_d.div_idx;
        end else begin
            if (tick) step <= step + 1'b1;
            if (wrap) begin
                act_lvl <= ctrl_d.level;
                act_div <= ctrl_d.div_idx;
            end
        end
    end

    assert_step_advance_R4: assert property (@(posedge clk) disable iff (rst)
        (run && tick && step != '1) |=> (step == $past(step) + 1'b1));

    assert_held_in_pd_R6: assert property (@(posedge clk) disable iff (rst)
        !run |=> (step == '0));

    assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (run && !wrap) |=> ($stable(act_lvl) && $stable(act_div)));

endmodule

// File: rtl/ledpwm_drive.sv
module ledpwm_drive
    import ledpwm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic drive_od,
    input  logic pwm_hi,
    output logic pwm_o,
    output logic pwm_oe
);

    drive_e mode;
    assign mode = drive_e'(drive_od);

    always_comb begin
        case (mode)
            DRV_OPENDRAIN: begin
                pwm_o  = 1'b0;
                pwm_oe = !pwm_hi;
            end
            default: begin
                pwm_o  = pwm_hi;
                pwm_oe = 1'b1;
            end
        endcase
    end

    assert_od_never_drives_high_R7: assert property (@(posedge clk) disable iff (rst)
        (drive_od && pwm_oe) |-> !pwm_o);

    assert_pp_always_driven_R7: assert property (@(posedge clk) disable iff (rst)
        !drive_od |-> pwm_oe);

endmodule

// File: rtl/ledpwm_top.sv
module ledpwm_top
    import ledpwm_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic              pwm_o,
    output logic              pwm_oe
);

    ctrl_t            ctrl_q;
    ctrl_t            ctrl_d;
    logic             tick;
    logic [DIV_W-1:0] act_div;
    logic             pwm_hi;

    ledpwm_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl_q(ctrl_q), .ctrl_d(ctrl_d)
    );

    ledpwm_prescaler u_pre (
        .clk(clk), .rst(rst), .run(ctrl_q.run), .div_idx(act_div), .tick(tick)
    );

    ledpwm_stepper u_step (
        .clk(clk), .rst(rst), .run(ctrl_q.run), .tick(tick),
        .ctrl_d(ctrl_d), .act_div(act_div), .pwm_hi(pwm_hi)
    );

    ledpwm_drive u_drv (
        .clk(clk), .rst(rst), .drive_od(ctrl_q.drive_od),
        .pwm_hi(pwm_hi), .pwm_o(pwm_o), .pwm_oe(pwm_oe)
    );

    assert_pd_low_R6: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.run |-> !pwm_hi);

    assert_reset_state_R2: assert property (@(posedge clk)
        $past(rst) |-> (pwm_oe && !pwm_o));

endmodule

// File: tb/sim_ledpwm_top.sv
module sim_ledpwm_top;

    localparam int CAP = 40000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_o;
    logic        pwm_oe;

    int checks = 0;
    int fails  = 0;
    int pin_bad = 0;
    bit cur_od = 1'b0;

    always #2 clk = ~clk;

    ledpwm_top u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_o(pwm_o), .pwm_oe(pwm_oe)
    );

    function automatic logic [15:0] mk(input bit od, input int lvl, input bit run, input int dv);
        logic [15:0] w;
        w = '0;
        w[15]   = od;
        w[12:8] = lvl[4:0];
        w[6]    = run;
        w[2:0]  = dv[2:0];
        return w;
    endfunction

    function automatic int step_len(input int dv);
        return 1 << (dv + 2);
    endfunction
    function automatic int exp_hi(input int dv, input int lvl);
        return (lvl + 1) * step_len(dv);
    endfunction
    function automatic int exp_lo(input int dv, input int lvl);
        return (31 - lvl) * step_len(dv);
    endfunction

    function automatic bit level_now();
        if (cur_od) begin
            if (pwm_o !== 1'b0) pin_bad++;
            return !pwm_oe;
        end
        if (pwm_oe !== 1'b1) pin_bad++;
        return pwm_o;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_len(input bit want, output int n);
        n = 0;
        while (level_now() == want && n < CAP) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic measure(input int dv, input int lvl, input bit od, input string tag);
        int h1, l1, h2, l2;
        cur_od = od;
        pin_bad = 0;
        wr(8'h18, mk(od, lvl, 1'b1, dv));
        run_len(1'b1, h1);
        run_len(1'b0, l1);
        run_len(1'b1, h2);
        run_len(1'b0, l2);
        chk(h1 == exp_hi(dv, lvl), {tag, " R4 high"}, h1, exp_hi(dv, lvl));
        chk(l1 == exp_lo(dv, lvl), {tag, " R4 low"}, l1, exp_lo(dv, lvl));
        chk(h2 + l2 == (1 << (dv + 7)), {tag, " R3 period"}, h2 + l2, 1 << (dv + 7));
        chk(pin_bad == 0, {tag, " R7 pin mode"}, pin_bad, 0);
    endtask

    task automatic power_down(input bit od, input int lvl, input int dv);
        int highs;
        cur_od = od;
        wr(8'h18, mk(od, lvl, 1'b0, dv));
        highs = 0;
        for (int i = 0; i < 12; i++) begin
            if (level_now()) highs++;
            @(negedge clk);
        end
        chk(highs == 0, "R6 powered down low", highs, 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R3 actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int seed_init;
        int highs;
        int h1, l1, h2, l2;
        seed_init = $urandom(32'd4711);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2: reset state
        chk(pwm_o == 1'b0, "R2 pwm_o after reset", int'(pwm_o), 0);
        chk(pwm_oe == 1'b1, "R2 pwm_oe after reset", int'(pwm_oe), 1);
        highs = 0;
        for (int i = 0; i < 40; i++) begin
            if (pwm_o) highs++;
            @(negedge clk);
        end
        chk(highs == 0, "R2 stays low", highs, 0);

        // R9: foreign address ignored
        wr(8'h19, mk(1'b0, 10, 1'b1, 0));
        wr(8'h98, mk(1'b0, 10, 1'b1, 0));
        highs = 0;
        for (int i = 0; i < 64; i++) begin
            if (pwm_o || !pwm_oe) highs++;
            @(negedge clk);
        end
        chk(highs == 0, "R9 foreign write ignored", highs, 0);

        // R4 directed: minimum level
        measure(0, 0, 1'b0, "lvl0");
        power_down(1'b0, 0, 0);

        // R5: full level, open drain
        cur_od = 1'b1;
        pin_bad = 0;
        wr(8'h18, mk(1'b1, 31, 1'b1, 1));
        highs = 0;
        for (int i = 0; i < 2 * 256; i++) begin
            if (level_now()) highs++;
            @(negedge clk);
        end
        chk(highs == 512, "R5 constant high", highs, 512);
        chk(pin_bad == 0, "R7 open drain at full level", pin_bad, 0);
        power_down(1'b1, 31, 1);

        // R1: reserved bits set have no effect
        cur_od = 1'b0;
        pin_bad = 0;
        wr(8'h18, mk(1'b0, 6, 1'b1, 1) | 16'h60B8);
        run_len(1'b1, h1);
        run_len(1'b0, l1);
        chk(h1 == exp_hi(1, 6), "R1 field decode high", h1, exp_hi(1, 6));
        chk(l1 == exp_lo(1, 6), "R1 field decode low", l1, exp_lo(1, 6));
        power_down(1'b0, 6, 1);

        // R3: largest scale
        measure(7, 5, 1'b0, "div7");
        power_down(1'b0, 5, 7);

        // random trials
        for (int t = 0; t < 8; t++) begin
            int dv, lv;
            bit od;
            dv = int'($urandom % 4);
            lv = int'($urandom % 31);
            od = bit'($urandom % 2);
            measure(dv, lv, od, "rand");
            power_down(od, lv, dv);
        end

        // R8: mid-period rewrite takes effect at the boundary
        cur_od = 1'b0;
        pin_bad = 0;
        wr(8'h18, mk(1'b0, 20, 1'b1, 1));
        fork
            begin
                repeat (3) @(negedge clk);
                wr_en = 1'b1; wr_addr = 8'h18; wr_data = mk(1'b0, 3, 1'b1, 0);
                @(negedge clk);
                wr_en = 1'b0;
            end
            begin
                run_len(1'b1, h1);
                run_len(1'b0, l1);
                run_len(1'b1, h2);
                run_len(1'b0, l2);
            end
        join
        chk(h1 == exp_hi(1, 20), "R8 old high kept", h1, exp_hi(1, 20));
        chk(l1 == exp_lo(1, 20), "R8 old low kept", l1, exp_lo(1, 20));
        chk(h2 == exp_hi(0, 3), "R8 new high", h2, exp_hi(0, 3));
        chk(l2 == exp_lo(0, 3), "R8 new low", l2, exp_lo(0, 3));

        // R6: disable mid-high then re-enable starts a fresh period high
        wr(8'h18, mk(1'b0, 3, 1'b0, 0));
        chk(level_now() == 1'b0, "R6 low right after disable", int'(pwm_o), 0);
        measure(2, 12, 1'b1, "reenable R6");

        finish_run();
    end

endmodule